// File: doc/BRIEF.md
# Serial MII Transmit Segment Receiver

This block sits on the PHY side of a serial MII link and turns the MAC's transmit stream back into parallel form. It watches a single serial data line and a sync line, both sampled on the rising edge of the 125 MHz reference clock. A sync pulse marks the first bit of a ten-bit segment. Each segment carries a transmit-error bit, a transmit-enable bit and one data byte.

The byte is presented with a one-cycle valid strobe and also as two nibbles for a four-bit datapath downstream. The block also gives a packet-active level and an error-symbol request level. In 100 Mbps mode every segment delivers a byte. In 10 Mbps mode the MAC repeats each segment ten times, so the block takes the byte from the first segment of each group of ten and drops the repeats.

A sync pulse that arrives inside a segment discards the partial segment, restarts framing at that pulse and reports the event for one cycle. When no sync is seen where a segment would begin, the line counts as idle and nothing is decoded.

Top module: `ser_tx_seg_rx`

## Requirements
- R1: While reset is asserted and right after it, byte_vld_o, byte_o, both nibbles, pkt_act_o, err_sym_o and sync_err_o are all zero.
- R2: In 100 Mbps mode (mode_10m_i = 0), each segment whose first bit coincides with tx_sync_i = 1 produces exactly one byte_vld_o pulse of one cycle. The pulse appears in the cycle after the segment's tenth bit is sampled. byte_o then holds that byte until the next strobe.
- R3: The serial order within a segment is: error bit, enable bit, then data bits 0 to 7, least significant first. nib_lo_o equals byte_o[3:0] and nib_hi_o equals byte_o[7:4].
- R4: pkt_act_o takes the enable bit of each completed segment and holds it until the next segment completes.
- R5: In 100 Mbps mode, err_sym_o takes the error bit of each completed segment and holds it until the next segment completes.
- R6: In 10 Mbps mode the error bit is ignored, and err_sym_o stays 0 even when the bit is set.
- R7: In 10 Mbps mode, segments are counted in groups of ten starting from the first segment after reset or after a misplaced sync. Only the first segment of each group produces a byte_vld_o strobe and updates byte_o.
- R8: A tx_sync_i pulse that arrives while a segment is part-way received raises sync_err_o for one cycle. It discards the partial segment without any strobe and starts a new segment at that pulse.
- R9: When no segment is in progress and tx_sync_i is 0, activity on tx_data_i produces no strobe and leaves all outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz reference clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_10m_i | input | 1 | 1 selects 10 Mbps, 0 selects 100 Mbps |
| tx_data_i | input | 1 | Serial transmit data from the MAC |
| tx_sync_i | input | 1 | Segment start pulse from the MAC |
| byte_vld_o | output | 1 | One-cycle strobe for a new byte |
| byte_o | output | 8 | Last captured data byte |
| nib_lo_o | output | 4 | Low nibble of byte_o |
| nib_hi_o | output | 4 | High nibble of byte_o |
| pkt_act_o | output | 1 | Enable bit of the latest segment |
| err_sym_o | output | 1 | Request for error symbols on the line |
| sync_err_o | output | 1 | One-cycle flag for a misplaced sync |

## Verification
In 100 Mbps mode the main path is driven with segments that have gaps between them and with segments sent back to back. The bytes have asymmetric bit patterns, so a reversed bit order or a swapped nibble shows up, and the enable and error bits are toggled to separate the two control positions. In 10 Mbps mode each group uses a first segment that differs from its nine repeats, which shows whether the byte comes from the first repeat and whether the group count starts at the right place. A truncated segment followed by a full one separates discarding the partial segment from decoding it. Toggling data on an idle line with no sync confirms that nothing is framed.

// File: rtl/ser_tx_seg_pkg.sv
package ser_tx_seg_pkg;
  localparam int DATA_W   = 8;
  localparam int NIB_W    = DATA_W / 2;
  localparam int RPT_SEGS = 10;

  // Packed so that bit 0 is the first serial bit received.
  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              en;
    logic              er;
  } seg_t;

  localparam int SEG_BITS = $bits(seg_t);
endpackage

// File: rtl/ser_seg_framer.sv
module ser_seg_framer
  import ser_tx_seg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sync_i,
  output logic take_o,
  output logic seg_end_o,
  output logic resync_o,
  output logic sync_err_o
);
  localparam int PW = $clog2(SEG_BITS);
  localparam logic [PW-1:0] LAST = PW'(SEG_BITS - 1);

  logic [PW-1:0] pos_q, pos_d, idx;
  logic          serr_q;

  always_comb begin
    resync_o  = sync_i && (pos_q != '0);
    take_o    = sync_i || (pos_q != '0);
    idx       = sync_i ? '0 : pos_q;
    seg_end_o = take_o && (idx == LAST);
    if (!take_o || (idx == LAST)) pos_d = '0;
    else                          pos_d = idx + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      serr_q <= 1'b0;
    end else begin
      pos_q  <= pos_d;
      serr_q <= resync_o;
    end
  end

  assign sync_err_o = serr_q;
endmodule

// File: rtl/ser_seg_shifter.sv
module ser_seg_shifter
  import ser_tx_seg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic take_i,
  input  logic bit_i,
  output seg_t seg_o
);
  logic [SEG_BITS-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = take_i ? {bit_i, sr_q[SEG_BITS-1:1]} : sr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  // Full segment as seen in the cycle its last bit is on the line.
  assign seg_o = seg_t'({bit_i, sr_q[SEG_BITS-1:1]});
endmodule

// File: rtl/ser_rate_ctrl.sv
module ser_rate_ctrl
  import ser_tx_seg_pkg::*;
#(
  parameter int GROUP = RPT_SEGS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_10m_i,
  input  logic seg_end_i,
  input  logic resync_i,
  output logic capture_o
);
  localparam int GW = (GROUP > 1) ? $clog2(GROUP) : 1;
  localparam logic [GW-1:0] GLAST = GW'(GROUP - 1);

  logic [GW-1:0] grp_q, grp_d;

  always_comb begin
    capture_o = seg_end_i && (!mode_10m_i || (grp_q == '0));
    if (resync_i || !mode_10m_i) grp_d = '0;
    else if (seg_end_i)          grp_d = (grp_q == GLAST) ? '0 : grp_q + GW'(1);
    else                         grp_d = grp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) grp_q <= '0;
    else        grp_q <= grp_d;
  end
endmodule

// File: rtl/ser_tx_seg_rx.sv
module ser_tx_seg_rx
  import ser_tx_seg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_10m_i,
  input  logic              tx_data_i,
  input  logic              tx_sync_i,
  output logic              byte_vld_o,
  output logic [DATA_W-1:0] byte_o,
  output logic [NIB_W-1:0]  nib_lo_o,
  output logic [NIB_W-1:0]  nib_hi_o,
  output logic              pkt_act_o,
  output logic              err_sym_o,
  output logic              sync_err_o
);
  logic take, seg_end, resync, capture;
  seg_t seg;

  logic              vld_q, vld_d;
  logic [DATA_W-1:0] byte_q, byte_d;
  logic              pkt_q, pkt_d;
  logic              err_q, err_d;
  logic [NIB_W-1:0]  nib [2];

  ser_seg_framer u_framer (
    .clk(clk), .rst_n(rst_n), .sync_i(tx_sync_i),
    .take_o(take), .seg_end_o(seg_end), .resync_o(resync),
    .sync_err_o(sync_err_o)
  );

  ser_seg_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .take_i(take), .bit_i(tx_data_i), .seg_o(seg)
  );

  ser_rate_ctrl #(.GROUP(RPT_SEGS)) u_rate (
    .clk(clk), .rst_n(rst_n), .mode_10m_i(mode_10m_i),
    .seg_end_i(seg_end), .resync_i(resync), .capture_o(capture)
  );

  always_comb begin
    vld_d  = capture;
    byte_d = capture ? seg.data : byte_q;
    pkt_d  = seg_end ? seg.en : pkt_q;
    err_d  = seg_end ? (seg.er && !mode_10m_i) : err_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      byte_q <= '0;
      pkt_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      vld_q  <= vld_d;
      byte_q <= byte_d;
      pkt_q  <= pkt_d;
      err_q  <= err_d;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_nib
    assign nib[g] = byte_q[g*NIB_W +: NIB_W];
  end

  assign byte_vld_o = vld_q;
  assign byte_o     = byte_q;
  assign nib_lo_o   = nib[0];
  assign nib_hi_o   = nib[1];
  assign pkt_act_o  = pkt_q;
  assign err_sym_o  = err_q;
endmodule

// File: rtl/ser_tx_seg_rx_chk.sv
module ser_tx_seg_rx_chk
  import ser_tx_seg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              mode_10m_i,
  input logic              byte_vld_i,
  input logic [DATA_W-1:0] byte_i,
  input logic              pkt_act_i,
  input logic              err_sym_i,
  input logic              sync_err_i,
  input logic              seg_end_i
);
  p_vld_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld_i |=> !byte_vld_i);

  p_byte_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_vld_i |-> $stable(byte_i));

  p_pkt_on_seg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pkt_act_i) |-> $past(seg_end_i));

  p_err_on_seg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(err_sym_i) |-> $past(seg_end_i));

  p_no_err_10m_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_sym_i) |-> !$past(mode_10m_i));

  p_serr_no_vld_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err_i |-> !byte_vld_i);
endmodule

bind ser_tx_seg_rx ser_tx_seg_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_10m_i(mode_10m_i),
  .byte_vld_i(byte_vld_o), .byte_i(byte_o), .pkt_act_i(pkt_act_o),
  .err_sym_i(err_sym_o), .sync_err_i(sync_err_o), .seg_end_i(seg_end)
);

// File: tb/tb_ser_tx_seg_rx.sv
module tb_ser_tx_seg_rx;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       mode_10m, tx_data, tx_sync;
  logic       byte_vld, pkt_act, err_sym, sync_err;
  logic [7:0] byte_out;
  logic [3:0] nib_lo, nib_hi;

  int checks = 0, fails = 0;
  int vld_cnt = 0, serr_cnt = 0;
  logic [7:0] last_byte = 8'h00;
  logic [3:0] last_lo = 4'h0, last_hi = 4'h0;

  always #2 clk = ~clk;

  ser_tx_seg_rx dut (
    .clk(clk), .rst_n(rst_n), .mode_10m_i(mode_10m), .tx_data_i(tx_data),
    .tx_sync_i(tx_sync), .byte_vld_o(byte_vld), .byte_o(byte_out),
    .nib_lo_o(nib_lo), .nib_hi_o(nib_hi), .pkt_act_o(pkt_act),
    .err_sym_o(err_sym), .sync_err_o(sync_err)
  );

  // Values seen here were stable for the whole preceding cycle.
  always @(posedge clk) begin
    if (rst_n && byte_vld) begin
      vld_cnt++;
      last_byte = byte_out;
      last_lo   = nib_lo;
      last_hi   = nib_hi;
    end
    if (rst_n && sync_err) serr_cnt++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n, input bit dval);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tx_sync = 1'b0;
      tx_data = dval;
    end
  endtask

  task automatic send_bits(input bit er, input bit en, input logic [7:0] d, input int n);
    logic [9:0] s;
    s = {d, en, er};
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tx_sync = (i == 0);
      tx_data = s[i];
    end
  endtask

  task automatic send_seg(input bit er, input bit en, input logic [7:0] d);
    send_bits(er, en, d, 10);
  endtask

  task automatic do_reset(input bit m);
    @(negedge clk);
    rst_n = 1'b0; mode_10m = m; tx_sync = 1'b0; tx_data = 1'b0;
    idle(3, 1'b0);
    rst_n = 1'b1;
    idle(1, 1'b0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst_n = 1'b0; mode_10m = 1'b0; tx_sync = 1'b0; tx_data = 1'b0;
    @(negedge clk);
    check(byte_vld == 0 && byte_out == 0 && nib_lo == 0 && nib_hi == 0,
          "R1 data outputs in reset", {byte_vld, byte_out}, 0);
    check(pkt_act == 0 && err_sym == 0 && sync_err == 0,
          "R1 flags in reset", {pkt_act, err_sym, sync_err}, 0);
    rst_n = 1'b1;
    idle(2, 1'b0);
    check(byte_vld == 0 && byte_out == 0 && pkt_act == 0 && err_sym == 0,
          "R1 after release", {byte_vld, byte_out, pkt_act, err_sym}, 0);
  endtask

  task automatic t_100m;
    int v0;
    do_reset(1'b0);
    v0 = vld_cnt;
    send_seg(1'b0, 1'b1, 8'hA5);
    @(negedge clk); tx_sync = 1'b0;
    check(byte_vld == 1'b1, "R2 strobe after tenth bit", byte_vld, 1);
    idle(1, 1'b0);
    check(byte_vld == 1'b0, "R2 strobe one cycle", byte_vld, 0);
    check(vld_cnt == v0 + 1, "R2 one strobe per segment", vld_cnt - v0, 1);
    check(last_byte == 8'hA5 && byte_out == 8'hA5, "R2 byte value", byte_out, 8'hA5);
    check(last_lo == 4'h5 && last_hi == 4'hA, "R3 nibble split", {last_hi, last_lo}, 8'hA5);
    check(pkt_act == 1'b1, "R4 enable set", pkt_act, 1);
    check(err_sym == 1'b0, "R5 error clear", err_sym, 0);
    v0 = vld_cnt;
    send_seg(1'b0, 1'b1, 8'h01);
    send_seg(1'b1, 1'b1, 8'h80);
    idle(2, 1'b0);
    check(vld_cnt == v0 + 2, "R2 back-to-back segments", vld_cnt - v0, 2);
    check(byte_out == 8'h80 && nib_hi == 4'h8 && nib_lo == 4'h0,
          "R3 bit order msb last", byte_out, 8'h80);
    check(err_sym == 1'b1, "R5 error set", err_sym, 1);
    send_seg(1'b0, 1'b0, 8'h7E);
    idle(2, 1'b0);
    check(pkt_act == 1'b0, "R4 enable cleared", pkt_act, 0);
    check(err_sym == 1'b0, "R5 error follows segment", err_sym, 0);
    check(byte_out == 8'h7E, "R2 last byte", byte_out, 8'h7E);
  endtask

  task automatic t_idle;
    int v0;
    v0 = vld_cnt;
    for (int i = 0; i < 25; i++) idle(1, i[0]);
    idle(2, 1'b0);
    check(vld_cnt == v0, "R9 no strobe on idle line", vld_cnt - v0, 0);
    check(byte_out == 8'h7E && pkt_act == 1'b0, "R9 outputs unchanged",
          {byte_out, pkt_act}, {8'h7E, 1'b0});
  endtask

  task automatic t_sync_err;
    int v0, s0;
    v0 = vld_cnt; s0 = serr_cnt;
    send_bits(1'b1, 1'b1, 8'hFF, 4);
    send_seg(1'b0, 1'b1, 8'h5A);
    idle(2, 1'b0);
    check(serr_cnt == s0 + 1, "R8 one sync error pulse", serr_cnt - s0, 1);
    check(vld_cnt == v0 + 1, "R8 partial discarded", vld_cnt - v0, 1);
    check(byte_out == 8'h5A, "R8 restart at pulse", byte_out, 8'h5A);
    check(err_sym == 1'b0, "R8 partial error bit dropped", err_sym, 0);
  endtask

  task automatic t_10m;
    int v0, s0;
    do_reset(1'b1);
    v0 = vld_cnt;
    send_seg(1'b1, 1'b1, 8'h11);
    for (int i = 0; i < 9; i++) send_seg(1'b1, 1'b1, 8'h99);
    idle(2, 1'b0);
    check(vld_cnt == v0 + 1, "R7 one byte per ten segments", vld_cnt - v0, 1);
    check(byte_out == 8'h11, "R7 byte from first segment", byte_out, 8'h11);
    check(err_sym == 1'b0, "R6 error bit ignored", err_sym, 0);
    check(pkt_act == 1'b1, "R4 enable in 10M", pkt_act, 1);
    v0 = vld_cnt;
    for (int i = 0; i < 10; i++) send_seg(1'b1, 1'b1, (i == 0) ? 8'h22 : 8'h66);
    idle(2, 1'b0);
    check(vld_cnt == v0 + 1 && byte_out == 8'h22, "R7 second group",
          byte_out, 8'h22);
    check(err_sym == 1'b0, "R6 still ignored", err_sym, 0);
    v0 = vld_cnt; s0 = serr_cnt;
    for (int i = 0; i < 3; i++) send_seg(1'b0, 1'b1, 8'h44);
    idle(2, 1'b0);
    check(vld_cnt == v0 + 1 && byte_out == 8'h44, "R7 group start", byte_out, 8'h44);
    send_bits(1'b0, 1'b1, 8'hEE, 5);
    send_seg(1'b0, 1'b1, 8'h33);
    idle(2, 1'b0);
    check(serr_cnt == s0 + 1, "R8 sync error in 10M", serr_cnt - s0, 1);
    check(vld_cnt == v0 + 2 && byte_out == 8'h33, "R7 count restarts on resync",
          byte_out, 8'h33);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode_10m = 1'b0; tx_sync = 1'b0; tx_data = 1'b0;
    t_reset();
    t_100m();
    t_idle();
    t_sync_err();
    t_10m();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule